// File: doc/BRIEF.md
# Quadrant SAD Accumulator for Double-Size Blocks

This block builds the sum of absolute differences (SAD) of a 2N×2N block by taking the SADs of its four N×N quadrants one quadrant pass after another. An upstream N×N adder tree streams one quadrant SAD per search location. The block keeps one running partial sum per search location in a RAM. Each incoming SAD is added to the stored entry for its location, and the sum is written back. The large block therefore costs one adder and a RAM, and needs no second, larger tree.

The block counts search locations itself. The location index starts at 0 and steps by one for each accepted sample. After the last location it wraps to 0 and the quadrant advances. Quadrants are taken in the order top-left, top-right, bottom-left, bottom-right. During the bottom-right pass each sum is final. It goes out on a registered stream together with its location index, so the minimum search that follows can tie it to a motion vector.

Both data sides use a valid/ready handshake. A sample moves when `in_valid` and `in_ready` are both high on a rising edge. A result moves when `out_valid` and `out_ready` are both high. `blk_start` is a plain control pulse that restarts the location and quadrant count.

Top module: `sad_quad_accum`

## Requirements
- R1: During reset and in the first cycle after it, `out_valid` is low and `in_ready` is high.
- R2: A sample taken in the top-left pass (quadrant 0) stores its own SAD in its location's entry and ignores what was held there before. No clear pass is needed between blocks, or after a block that was abandoned.
- R3: Samples taken in quadrants 1 (top-right) and 2 (bottom-left) add their SAD to the entry of their location and write the sum back. They produce no output.
- R4: For each sample taken in quadrant 3 (bottom-right), `out_sad` is the sum of the four quadrant SADs taken for that location since the last restart, with no wrap-around. Inputs are IN_W = 20 bits wide and sums are ACC_W = 22 bits wide.
- R5: The location index of accepted samples runs 0, 1, … NUM_LOC−1 (default 4096). It then wraps to 0 and the quadrant number advances by one, wrapping from 3 back to 0 to begin the next block. `out_loc` carries the index of the sample that produced the result.
- R6: While `blk_start` is high, the index and quadrant are forced to 0. A sample accepted in the same cycle is location 0 of quadrant 0.
- R7: A quadrant-3 sample accepted on edge k has its result on the outputs after edge k+1 when `out_ready` is high. With `out_ready` held high, gap-free input yields one result per cycle.
- R8: The sum is correct when the same location is read in the cycle its previous sum is written back. This case occurs every cycle when NUM_LOC = 1.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_sad` and `out_loc` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_start | input | 1 | Restarts the location index and quadrant at 0 |
| in_valid | input | 1 | Quadrant SAD sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sad | input | IN_W (20) | Quadrant SAD for the current location |
| out_valid | output | 1 | Final large-block SAD present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_sad | output | ACC_W (22) | Sum of the four quadrant SADs |
| out_loc | output | LOC_W (12) | Search location index of `out_sad` |

## Verification
The bench re-runs a block after a restart in the middle of the bottom-left pass. A design that cleared nothing and added in quadrant 0 would then report sums inflated by the stale partials. It drives a location whose four quadrant SADs are all at full scale, so a narrowed adder would show a wrapped value. Gap-free passes check the two-edge latency and the one-result-per-cycle rate, while random back-pressure checks that a held result does not change. A one-entry instance reads and writes the same entry every cycle. Without forwarding, that instance would add to a stale value and lose the previous quadrant's SAD.

// File: rtl/sadacc_pkg.sv
`timescale 1ns/1ps
package sadacc_pkg;
  // Quadrant processing order; the numeric value is the pass number.
  typedef enum logic [1:0] {
    QD_TL = 2'd0,
    QD_TR = 2'd1,
    QD_BL = 2'd2,
    QD_BR = 2'd3
  } quad_e;
endpackage

// File: rtl/sadacc_seq.sv
`timescale 1ns/1ps
// Location / quadrant sequencer: one step per accepted sample.
module sadacc_seq
  import sadacc_pkg::*;
#(
  parameter int NUM_LOC = 4096,
  parameter int LOC_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             take,
  output logic [LOC_W-1:0] cur_loc,
  output quad_e            cur_quad
);
  localparam logic [LOC_W-1:0] LAST_LOC = LOC_W'(NUM_LOC - 1);

  logic [LOC_W-1:0] loc_q;
  quad_e            quad_q;
  logic             at_last;
  logic [1:0]       quad_nxt;

  always_comb begin
    cur_loc  = blk_start ? '0 : loc_q;
    cur_quad = blk_start ? QD_TL : quad_q;
    at_last  = (cur_loc == LAST_LOC);
    quad_nxt = 2'(cur_quad) + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q  <= '0;
      quad_q <= QD_TL;
    end else if (take) begin
      loc_q  <= at_last ? '0 : cur_loc + LOC_W'(1);
      quad_q <= at_last ? quad_e'(quad_nxt) : cur_quad;
    end else if (blk_start) begin
      loc_q  <= '0;
      quad_q <= QD_TL;
    end
  end
endmodule

// File: rtl/sadacc_ram.sv
`timescale 1ns/1ps
// Partial-sum store: one synchronous read port, one write port,
// read returns the value held before a same-edge write.
module sadacc_ram #(
  parameter int DEPTH = 4096,
  parameter int AW    = 12,
  parameter int DW    = 22
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  generate
    if (DEPTH == 1) begin : g_single
      logic [DW-1:0] cell_q;
      always_ff @(posedge clk) begin
        if (wr_en) cell_q <= wr_data;
        if (rd_en) rd_data <= cell_q;
      end
    end else begin : g_array
      logic [DW-1:0] mem_q [DEPTH];
      always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem_q[rd_addr];
      end
    end
  endgenerate
endmodule

// File: rtl/sadacc_fold.sv
`timescale 1ns/1ps
// Selects the prior partial sum (none, forwarded or stored) and adds the new SAD.
module sadacc_fold #(
  parameter int IN_W  = 20,
  parameter int ACC_W = 22
) (
  input  logic             first_pass,
  input  logic             fwd_hit,
  input  logic [ACC_W-1:0] fwd_val,
  input  logic [ACC_W-1:0] ram_val,
  input  logic [IN_W-1:0]  sad_in,
  output logic [ACC_W-1:0] sum
);
  logic [ACC_W-1:0] base;

  always_comb begin
    if (first_pass)   base = '0;
    else if (fwd_hit) base = fwd_val;
    else              base = ram_val;
    sum = base + ACC_W'(sad_in);
  end
endmodule

// File: rtl/sad_quad_accum.sv
`timescale 1ns/1ps
// Builds 2Nx2N SADs from four sequential NxN quadrant passes.
module sad_quad_accum
  import sadacc_pkg::*;
#(
  parameter int  NUM_LOC = 4096,
  parameter int  IN_W    = 20,
  parameter int  ACC_W   = 22,
  localparam int LOC_W   = (NUM_LOC > 1) ? $clog2(NUM_LOC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_start,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_sad,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [ACC_W-1:0] out_sad,
  output logic [LOC_W-1:0] out_loc
);
  logic             adv;
  logic             take;
  logic [LOC_W-1:0] cur_loc;
  quad_e            cur_quad;

  // read stage -> add/write stage
  logic             s1_v;
  logic [LOC_W-1:0] s1_loc;
  logic [IN_W-1:0]  s1_sad;
  quad_e            s1_quad;
  logic             s1_fwd;
  logic [ACC_W-1:0] s1_fwd_val;
  logic [ACC_W-1:0] ram_rd;
  logic [ACC_W-1:0] sum;
  logic             wr_en;

  // Whole pipeline moves only when the output slot can take a value.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;
  assign take     = in_valid && adv;
  assign wr_en    = s1_v && adv;

  sadacc_seq #(
    .NUM_LOC (NUM_LOC),
    .LOC_W   (LOC_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .blk_start (blk_start),
    .take      (take),
    .cur_loc   (cur_loc),
    .cur_quad  (cur_quad)
  );

  sadacc_ram #(
    .DEPTH (NUM_LOC),
    .AW    (LOC_W),
    .DW    (ACC_W)
  ) u_ram (
    .clk     (clk),
    .rd_en   (take),
    .rd_addr (cur_loc),
    .rd_data (ram_rd),
    .wr_en   (wr_en),
    .wr_addr (s1_loc),
    .wr_data (sum)
  );

  sadacc_fold #(
    .IN_W  (IN_W),
    .ACC_W (ACC_W)
  ) u_fold (
    .first_pass (s1_quad == QD_TL),
    .fwd_hit    (s1_fwd),
    .fwd_val    (s1_fwd_val),
    .ram_val    (ram_rd),
    .sad_in     (s1_sad),
    .sum        (sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v       <= 1'b0;
      s1_loc     <= '0;
      s1_sad     <= '0;
      s1_quad    <= QD_TL;
      s1_fwd     <= 1'b0;
      s1_fwd_val <= '0;
    end else if (adv) begin
      s1_v <= take;
      if (take) begin
        s1_loc     <= cur_loc;
        s1_sad     <= in_sad;
        s1_quad    <= cur_quad;
        // RAM read on this edge misses the write of the same edge
        s1_fwd     <= s1_v && (s1_loc == cur_loc);
        s1_fwd_val <= sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sad   <= '0;
      out_loc   <= '0;
    end else if (adv) begin
      out_valid <= s1_v && (s1_quad == QD_BR);
      if (s1_v && (s1_quad == QD_BR)) begin
        out_sad <= sum;
        out_loc <= s1_loc;
      end
    end
  end
endmodule

// File: rtl/sad_quad_accum_chk.sv
`timescale 1ns/1ps
module sad_quad_accum_chk #(
  parameter int NUM_LOC = 4096,
  parameter int IN_W    = 20,
  parameter int ACC_W   = 22,
  parameter int LOC_W   = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             blk_start,
  input logic             take,
  input logic             adv,
  input logic [LOC_W-1:0] cur_loc,
  input logic             s1_v,
  input logic [1:0]       s1_quad,
  input logic [IN_W-1:0]  s1_sad,
  input logic [ACC_W-1:0] sum,
  input logic             out_valid,
  input logic             out_ready,
  input logic [ACC_W-1:0] out_sad,
  input logic [LOC_W-1:0] out_loc
);
  // R3: passes before bottom-right emit nothing
  a_r3_no_early_out: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_v && s1_quad != 2'd3) |=> !out_valid);

  // R4: accumulation never wraps
  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_v && s1_quad != 2'd0) |-> (sum >= ACC_W'(s1_sad)));

  // R5: index steps by one per accepted sample
  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cur_loc != LOC_W'(NUM_LOC - 1)) |=>
      (blk_start || cur_loc == $past(cur_loc) + LOC_W'(1)));

  // R5: index wraps after the last location
  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cur_loc == LOC_W'(NUM_LOC - 1)) |=> (cur_loc == '0));

  // R6: restart without a sample leaves index at zero
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !take) |=> (cur_loc == '0));

  // R7: bottom-right sum reaches the output register
  a_r7_result: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && s1_v && s1_quad == 2'd3) |=> out_valid);

  // R9: stalled result holds
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_sad) && $stable(out_loc)));
endmodule

bind sad_quad_accum sad_quad_accum_chk #(
  .NUM_LOC (NUM_LOC),
  .IN_W    (IN_W),
  .ACC_W   (ACC_W),
  .LOC_W   (LOC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .blk_start (blk_start),
  .take      (take),
  .adv       (adv),
  .cur_loc   (cur_loc),
  .s1_v      (s1_v),
  .s1_quad   (s1_quad),
  .s1_sad    (s1_sad),
  .sum       (sum),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sad   (out_sad),
  .out_loc   (out_loc)
);

// File: tb/sad_quad_accum_tb.sv
`timescale 1ns/1ps
module sad_quad_accum_tb;
  localparam int N  = 4096;
  localparam int IW = 20;
  localparam int AW = 22;
  localparam int LW = 12;
  localparam logic [IW-1:0] MAXS = {IW{1'b1}};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, blk_start, in_valid, in_ready, out_valid, out_ready;
  logic [IW-1:0] in_sad;
  logic [AW-1:0] out_sad;
  logic [LW-1:0] out_loc;

  // one-entry instance for the forwarding case
  logic          b_start, b_valid, b_ready, b_ovalid;
  logic [IW-1:0] b_sad;
  logic [AW-1:0] b_osad;
  logic [0:0]    b_oloc;

  sad_quad_accum u_dut (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_sad(in_sad),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_sad(out_sad), .out_loc(out_loc));

  sad_quad_accum #(.NUM_LOC(1)) u_dut_one (
    .clk(clk), .rst_n(rst_n), .blk_start(b_start),
    .in_valid(b_valid), .in_ready(b_ready), .in_sad(b_sad),
    .out_valid(b_ovalid), .out_ready(1'b1),
    .out_sad(b_osad), .out_loc(b_oloc));

  int n_chk = 0;
  int n_bad = 0;

  task automatic check_eq(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // ---------------- reference model (main instance)
  int unsigned mmem [N];
  int          mloc = 0, mquad = 0;
  int unsigned q_sad [$];
  int          q_loc [$];
  int          q_t   [$];
  bit          mon_on = 0, timing_on = 0, rnd_ready = 0;
  int          negcnt = 0;
  bit            pstall = 0;
  logic [AW-1:0] p_sad;
  logic [LW-1:0] p_loc;

  always @(negedge clk) if (mon_on) begin
    negcnt++;
    check_eq("R9 in_ready rule", in_ready, (!out_valid || out_ready));
    if (pstall) begin
      check_eq("R9 held valid", out_valid, 1);
      check_eq("R9 held sad", out_sad, p_sad);
      check_eq("R9 held loc", out_loc, p_loc);
    end
    pstall = out_valid && !out_ready;
    p_sad  = out_sad;
    p_loc  = out_loc;
    if (out_valid && out_ready) begin
      if (q_sad.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R3 output outside bottom-right pass: actual loc %0d expected none", out_loc);
      end else begin
        int unsigned es;
        int el, et;
        es = q_sad.pop_front(); el = q_loc.pop_front(); et = q_t.pop_front();
        check_eq("R2/R4 large-block sum", out_sad, es);
        check_eq("R5/R6 result location", out_loc, el);
        if (timing_on) check_eq("R7 latency in cycles", negcnt - et, 2);
      end
    end
    if (blk_start) begin mloc = 0; mquad = 0; end
    if (in_valid && in_ready) begin
      if (mquad == 0) mmem[mloc] = in_sad;
      else            mmem[mloc] = mmem[mloc] + in_sad;
      if (mquad == 3) begin q_sad.push_back(mmem[mloc]); q_loc.push_back(mloc); q_t.push_back(negcnt); end
      if (mloc == N-1) begin mloc = 0; mquad = (mquad + 1) % 4; end
      else mloc++;
    end
  end

  // ---------------- reference model (one-entry instance), R8
  int unsigned bacc = 0;
  int          bquad = 0;
  int unsigned bq [$];
  int          b_outs = 0;

  always @(negedge clk) if (mon_on) begin
    if (b_ovalid) begin
      b_outs++;
      if (bq.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R8 unexpected result: actual %0d expected none", b_osad);
      end else check_eq("R8 back-to-back same entry sum", b_osad, bq.pop_front());
    end
    if (b_start) bquad = 0;
    if (b_valid && b_ready) begin
      bacc = (bquad == 0) ? b_sad : bacc + b_sad;
      if (bquad == 3) bq.push_back(bacc);
      bquad = (bquad + 1) % 4;
    end
  end

  // ---------------- out_ready driver
  always @(posedge clk) begin
    #1;
    out_ready = rnd_ready ? (($urandom % 100) < 70) : 1'b1;
  end

  // ---------------- stimulus tasks (entered at posedge + 1)
  task automatic send(input logic [IW-1:0] s, input int gap);
    bit got;
    while (gap > 0 && ($urandom % 100) < gap) begin
      in_valid = 1'b0; @(posedge clk); #1;
    end
    in_valid = 1'b1; in_sad = s;
    do begin @(negedge clk); got = in_ready; @(posedge clk); #1; end while (!got);
    in_valid = 1'b0;
  endtask

  task automatic pulse_start();
    blk_start = 1'b1; @(posedge clk); #1; blk_start = 1'b0;
  endtask

  function automatic logic [IW-1:0] pick(input int loc);
    if (loc == 5 || loc == N-1) return MAXS;
    if (loc == 6) return '0;
    return IW'($urandom) & MAXS;
  endfunction

  task automatic run_samples(input int count, input int gap, input bit start_with);
    for (int k = 0; k < count; k++) begin
      if (k == 0 && start_with) blk_start = 1'b1;
      send(pick(k % N), gap);
      blk_start = 1'b0;
    end
  endtask

  // ---------------- watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // ---------------- main sequence
  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; blk_start = 1'b0; in_valid = 1'b0; in_sad = '0;
    b_start = 1'b0; b_valid = 1'b0; b_sad = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R1 out_valid in reset", out_valid, 0);
    check_eq("R1 in_ready in reset", in_ready, 1);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 out_valid after reset", out_valid, 0);
    check_eq("R1 in_ready after reset", in_ready, 1);
    @(posedge clk); #1;
    mon_on = 1'b1;

    // directed: gap-free block, no stalls, latency and rate (R7, R4 full scale)
    timing_on = 1'b1;
    pulse_start();
    run_samples(4*N, 0, 1'b0);
    repeat (6) @(posedge clk); #1;
    timing_on = 1'b0;
    check_eq("R7 all results of gap-free block delivered", q_sad.size(), 0);

    // random: abandoned block then fresh blocks (R2, R6), back-pressure (R9)
    rnd_ready = 1'b1;
    pulse_start();
    run_samples(2*N + N/2, 15, 1'b0);
    pulse_start();
    run_samples(4*N, 15, 1'b0);
    run_samples(4*N, 10, 1'b1);
    rnd_ready = 1'b0;
    repeat (10) @(posedge clk); #1;
    check_eq("R4 no pending results", q_sad.size(), 0);
    check_eq("R5 model index back at zero", mloc, 0);

    // one-entry instance: same address read while written (R8)
    b_start = 1'b1; @(posedge clk); #1; b_start = 1'b0;
    for (int k = 0; k < 12; k++) begin
      b_valid = 1'b1;
      b_sad = (k == 4) ? MAXS : (IW'($urandom) & MAXS);
      @(posedge clk); #1;
    end
    b_valid = 1'b0;
    repeat (5) @(posedge clk); #1;
    check_eq("R8 result count", b_outs, 3);
    check_eq("R8 no pending", bq.size(), 0);

    summary();
    $finish;
  end
endmodule